// File: doc/BRIEF.md
# Frame-Stepped Calendar and Time-of-Day Counter

This block holds a calendar date and a time of day as packed decimal fields and moves them forward in step with an interlaced video signal. Each field-sync strobe is counted, and the time advances only once both fields of a frame have passed. As a result, the value stays the same over the two half-frames that make up one picture. One frame is worth 0.04 s, so the hundredths field goes up by four on each frame. Carries then pass upward in one cycle through seconds, minutes, hours, day, month and year.

An external time source, such as a satellite receiver front end, sets every field at once with a load strobe. This happens at power-on and again whenever a fresh reading arrives. A load always takes effect, even over an increment in the same cycle. A load also restarts the field pairing, so the next strobe counts as the first field of a new frame.

Top module: `dt_frame_clock`

## Requirements
- R1: After reset the fields read day 0x01, month 1, year 0x00, hours 0x00, minutes 0x00, seconds 0x00, hundredths 0x00.
- R2: Decimal fields are packed BCD, tens in bits 7:4 and units in bits 3:0. Month is a 4-bit binary value from 1 to 12. Hundredths rise by 4 on every second field strobe. The first strobe after reset or after a load changes no field.
- R3: Hundredths at 0x96 go to 0x00 on a frame, and seconds rise by one.
- R4: Seconds go from 0x59 to 0x00 with a carry into minutes. Minutes go from 0x59 to 0x00 with a carry into hours.
- R5: Hours go from 0x23 to 0x00 with a carry into the day.
- R6: The day wraps after the last day of the month and returns to 0x01, and the month rises by one. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the two-digit year is divisible by 4 (year 00 included) and 28 otherwise. All other months have 31 days.
- R7: The month goes from 12 to 1 with a carry into the year. The year goes from 0x99 to 0x00.
- R8: When load_en is high, every field takes its load value at that clock edge, even if a frame would also advance in that cycle. The field pairing restarts, so a further two strobes are needed for the next advance.
- R9: In a cycle with neither a completing frame nor a load, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_tick | input | 1 | One-cycle strobe for each video field sync |
| load_en | input | 1 | One-cycle strobe that loads every field |
| ld_day | input | 8 | Day value to load, BCD |
| ld_month | input | 4 | Month value to load, binary 1..12 |
| ld_year | input | 8 | Two-digit year value to load, BCD |
| ld_hour | input | 8 | Hours value to load, BCD |
| ld_min | input | 8 | Minutes value to load, BCD |
| ld_sec | input | 8 | Seconds value to load, BCD |
| ld_hund | input | 8 | Hundredths value to load, BCD |
| day_bcd | output | 8 | Day of month, BCD |
| month_bin | output | 4 | Month, binary |
| year_bcd | output | 8 | Two-digit year, BCD |
| hour_bcd | output | 8 | Hours, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| sec_bcd | output | 8 | Seconds, BCD |
| hund_bcd | output | 8 | Hundredths of a second, BCD |

## Verification
A long run of plain strobes from reset covers the hundredths across many seconds. It shows whether the step of four, the every-other-strobe gating and the 0x96 wrap are right. Loads placed just below each boundary (end of minute, end of hour, end of day) show whether each carry reaches exactly one level further. The sweep over all twelve months, in a leap year and in a common year, shows whether the month-length rule is correct, and December 31 of year 99 shows whether the full carry chain reaches the top. A load issued together with a completing strobe, followed by single strobes, shows whether the load wins and whether the pairing restarts.

// File: rtl/dt_pkg.sv
package dt_pkg;

   // packed two-digit BCD to binary (0..99)
   function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
      return ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
   endfunction

   // binary (0..99) to packed two-digit BCD
   function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
      logic [6:0] tens;
      logic [6:0] units;
      tens  = v / 7'd10;
      units = v - (tens * 7'd10);
      return {tens[3:0], units[3:0]};
   endfunction

   localparam logic [3:0] MONTH_LAST = 4'd12;

endpackage

// File: rtl/dt_frame_gate.sv
module dt_frame_gate #(
   parameter int FIELDS_PER_FRAME = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic field_tick,
   input  logic clear,
   output logic frame_adv
);

   generate
      if (FIELDS_PER_FRAME == 1) begin : g_direct
         assign frame_adv = field_tick & ~clear;
      end else begin : g_count
         localparam int CW = $clog2(FIELDS_PER_FRAME);
         localparam logic [CW-1:0] LAST = CW'(FIELDS_PER_FRAME - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               cnt_q <= '0;
            end else if (field_tick) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
         end

         assign frame_adv = field_tick & ~clear & (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/dt_wrap_pair.sv
module dt_wrap_pair (
   input  logic       en,
   input  logic [7:0] cur_bcd,
   input  logic [6:0] step,
   input  logic [6:0] last,
   input  logic [6:0] first,
   output logic [7:0] nxt_bcd,
   output logic       carry
);
   import dt_pkg::*;

   logic [7:0] sum;
   logic [7:0] wrapped;
   logic       over;
   logic [6:0] res;

   always_comb begin
      sum     = {1'b0, bcd_to_bin(cur_bcd)} + {1'b0, step};
      over    = sum > {1'b0, last};
      wrapped = {1'b0, first} + sum - {1'b0, last} - 8'd1;
      res     = over ? wrapped[6:0] : sum[6:0];
      nxt_bcd = en ? bin_to_bcd(res) : cur_bcd;
      carry   = en & over;
   end

endmodule

// File: rtl/dt_month_len.sv
module dt_month_len (
   input  logic [3:0] month,
   input  logic [7:0] year_bcd,
   output logic [6:0] last_day
);
   import dt_pkg::*;

   logic [6:0] year_bin;
   logic       leap;

   always_comb begin
      year_bin = bcd_to_bin(year_bcd);
      leap     = (year_bin[1:0] == 2'b00);
      case (month)
         4'd2:                      last_day = leap ? 7'd29 : 7'd28;
         4'd4, 4'd6, 4'd9, 4'd11:   last_day = 7'd30;
         default:                   last_day = 7'd31;
      endcase
   end

endmodule

// File: rtl/dt_frame_clock.sv
module dt_frame_clock #(
   parameter int HUND_STEP        = 4,
   parameter int FIELDS_PER_FRAME = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       field_tick,
   input  logic       load_en,
   input  logic [7:0] ld_day,
   input  logic [3:0] ld_month,
   input  logic [7:0] ld_year,
   input  logic [7:0] ld_hour,
   input  logic [7:0] ld_min,
   input  logic [7:0] ld_sec,
   input  logic [7:0] ld_hund,
   output logic [7:0] day_bcd,
   output logic [3:0] month_bin,
   output logic [7:0] year_bcd,
   output logic [7:0] hour_bcd,
   output logic [7:0] min_bcd,
   output logic [7:0] sec_bcd,
   output logic [7:0] hund_bcd
);
   import dt_pkg::*;

   localparam logic [6:0] STEP7 = 7'(HUND_STEP);

   generate
      if (HUND_STEP < 1 || HUND_STEP > 99 || (100 % HUND_STEP) != 0) begin : g_bad_step
         $error("HUND_STEP must divide 100 and lie in 1..99");
      end
      if (FIELDS_PER_FRAME < 1) begin : g_bad_fields
         $error("FIELDS_PER_FRAME must be at least 1");
      end
   endgenerate

   logic       frame_adv;
   logic [7:0] day_q, year_q, hour_q, min_q, sec_q, hund_q;
   logic [3:0] mon_q;
   logic [7:0] day_n, year_n, hour_n, min_n, sec_n, hund_n;
   logic [3:0] mon_n;
   logic       c_hund, c_sec, c_min, c_hour, c_day, c_mon, c_year;
   logic [6:0] mlast;

   dt_frame_gate #(.FIELDS_PER_FRAME(FIELDS_PER_FRAME)) u_gate (
      .clk(clk), .rst_n(rst_n), .field_tick(field_tick),
      .clear(load_en), .frame_adv(frame_adv)
   );

   dt_wrap_pair u_hund (.en(frame_adv), .cur_bcd(hund_q), .step(STEP7),
      .last(7'd99), .first(7'd0), .nxt_bcd(hund_n), .carry(c_hund));
   dt_wrap_pair u_sec  (.en(c_hund), .cur_bcd(sec_q), .step(7'd1),
      .last(7'd59), .first(7'd0), .nxt_bcd(sec_n), .carry(c_sec));
   dt_wrap_pair u_min  (.en(c_sec), .cur_bcd(min_q), .step(7'd1),
      .last(7'd59), .first(7'd0), .nxt_bcd(min_n), .carry(c_min));
   dt_wrap_pair u_hour (.en(c_min), .cur_bcd(hour_q), .step(7'd1),
      .last(7'd23), .first(7'd0), .nxt_bcd(hour_n), .carry(c_hour));

   dt_month_len u_mlen (.month(mon_q), .year_bcd(year_q), .last_day(mlast));

   dt_wrap_pair u_day  (.en(c_hour), .cur_bcd(day_q), .step(7'd1),
      .last(mlast), .first(7'd1), .nxt_bcd(day_n), .carry(c_day));

   always_comb begin
      c_mon = c_day & (mon_q >= MONTH_LAST);
      if (!c_day)     mon_n = mon_q;
      else if (c_mon) mon_n = 4'd1;
      else            mon_n = mon_q + 4'd1;
   end

   dt_wrap_pair u_year (.en(c_mon), .cur_bcd(year_q), .step(7'd1),
      .last(7'd99), .first(7'd0), .nxt_bcd(year_n), .carry(c_year));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         day_q  <= 8'h01;
         mon_q  <= 4'd1;
         year_q <= 8'h00;
         hour_q <= 8'h00;
         min_q  <= 8'h00;
         sec_q  <= 8'h00;
         hund_q <= 8'h00;
      end else if (load_en) begin
         day_q  <= ld_day;
         mon_q  <= ld_month;
         year_q <= ld_year;
         hour_q <= ld_hour;
         min_q  <= ld_min;
         sec_q  <= ld_sec;
         hund_q <= ld_hund;
      end else if (frame_adv) begin
         day_q  <= day_n;
         mon_q  <= mon_n;
         year_q <= year_n;
         hour_q <= hour_n;
         min_q  <= min_n;
         sec_q  <= sec_n;
         hund_q <= hund_n;
      end
   end

   // year carry has no consumer beyond the top field
   logic unused_carry;
   assign unused_carry = c_year;

   assign day_bcd   = day_q;
   assign month_bin = mon_q;
   assign year_bcd  = year_q;
   assign hour_bcd  = hour_q;
   assign min_bcd   = min_q;
   assign sec_bcd   = sec_q;
   assign hund_bcd  = hund_q;

endmodule

// File: rtl/dt_frame_clock_chk.sv
module dt_frame_clock_chk #(
   parameter int HUND_STEP = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       field_tick,
   input logic       load_en,
   input logic [7:0] ld_day,
   input logic [3:0] ld_month,
   input logic [7:0] ld_year,
   input logic [7:0] ld_hour,
   input logic [7:0] ld_min,
   input logic [7:0] ld_sec,
   input logic [7:0] ld_hund,
   input logic [7:0] day_bcd,
   input logic [3:0] month_bin,
   input logic [7:0] year_bcd,
   input logic [7:0] hour_bcd,
   input logic [7:0] min_bcd,
   input logic [7:0] sec_bcd,
   input logic [7:0] hund_bcd
);
   import dt_pkg::*;

   assert_hund_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> (hund_bcd == $past(hund_bcd)) ||
         (int'(bcd_to_bin(hund_bcd)) == (int'(bcd_to_bin($past(hund_bcd))) + HUND_STEP) % 100));

   assert_sec_needs_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && hund_bcd != 8'h96) |=> $stable(sec_bcd));

   assert_min_needs_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && sec_bcd != 8'h59) |=> $stable(min_bcd));

   assert_day_needs_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && hour_bcd != 8'h23) |=> $stable(day_bcd));

   assert_day_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (day_bcd != 8'h00) && (month_bin >= 4'd1) && (month_bin <= 4'd12));

   assert_year_needs_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && month_bin != 4'd12) |=> $stable(year_bcd));

   assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (day_bcd == $past(ld_day)) && (month_bin == $past(ld_month)) &&
         (year_bcd == $past(ld_year)) && (hour_bcd == $past(ld_hour)) &&
         (min_bcd == $past(ld_min)) && (sec_bcd == $past(ld_sec)) &&
         (hund_bcd == $past(ld_hund)));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !field_tick) |=> $stable(hund_bcd) && $stable(day_bcd) &&
         $stable(month_bin) && $stable(hour_bcd));

endmodule

bind dt_frame_clock dt_frame_clock_chk #(.HUND_STEP(HUND_STEP)) u_chk (.*);

// File: tb/dt_frame_clock_bench.sv
module dt_frame_clock_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       field_tick = 1'b0;
   logic       load_en = 1'b0;
   logic [7:0] ld_day = 8'h00, ld_year = 8'h00, ld_hour = 8'h00;
   logic [7:0] ld_min = 8'h00, ld_sec = 8'h00, ld_hund = 8'h00;
   logic [3:0] ld_month = 4'd0;
   logic [7:0] day_bcd, year_bcd, hour_bcd, min_bcd, sec_bcd, hund_bcd;
   logic [3:0] month_bin;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench model, binary values
   int m_day, m_mon, m_year, m_hr, m_min, m_sec, m_hun, m_par;

   always #4 clk = ~clk;

   dt_frame_clock u_dt_frame_clock (
      .clk(clk), .rst_n(rst_n), .field_tick(field_tick), .load_en(load_en),
      .ld_day(ld_day), .ld_month(ld_month), .ld_year(ld_year), .ld_hour(ld_hour),
      .ld_min(ld_min), .ld_sec(ld_sec), .ld_hund(ld_hund),
      .day_bcd(day_bcd), .month_bin(month_bin), .year_bcd(year_bcd),
      .hour_bcd(hour_bcd), .min_bcd(min_bcd), .sec_bcd(sec_bcd), .hund_bcd(hund_bcd)
   );

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int month_days(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   task automatic model_frame();
      m_hun += 4;
      if (m_hun >= 100) begin
         m_hun -= 100; m_sec++;
         if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
               m_min = 0; m_hr++;
               if (m_hr == 24) begin
                  m_hr = 0; m_day++;
                  if (m_day > month_days(m_mon, m_year)) begin
                     m_day = 1; m_mon++;
                     if (m_mon > 12) begin
                        m_mon = 1; m_year = (m_year + 1) % 100;
                     end
                  end
               end
            end
         end
      end
   endtask

   task automatic check(input string tag);
      logic [51:0] got, exp;
      got = {day_bcd, month_bin, year_bcd, hour_bcd, min_bcd, sec_bcd, hund_bcd};
      exp = {to_bcd(m_day), 4'(m_mon), to_bcd(m_year), to_bcd(m_hr),
             to_bcd(m_min), to_bcd(m_sec), to_bcd(m_hun)};
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic strobe();
      @(negedge clk);
      field_tick = 1'b1;
      @(negedge clk);
      field_tick = 1'b0;
      m_par++;
      if (m_par == 2) begin
         m_par = 0;
         model_frame();
      end
   endtask

   task automatic load(input int d, input int mo, input int y, input int h,
                       input int mi, input int s, input int hu, input bit with_tick);
      @(negedge clk);
      load_en = 1'b1; field_tick = with_tick;
      ld_day = to_bcd(d); ld_month = 4'(mo); ld_year = to_bcd(y);
      ld_hour = to_bcd(h); ld_min = to_bcd(mi); ld_sec = to_bcd(s); ld_hund = to_bcd(hu);
      @(negedge clk);
      load_en = 1'b0; field_tick = 1'b0;
      m_day = d; m_mon = mo; m_year = y; m_hr = h; m_min = mi; m_sec = s; m_hun = hu;
      m_par = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      m_day = 1; m_mon = 1; m_year = 0; m_hr = 0; m_min = 0; m_sec = 0; m_hun = 0; m_par = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state");

      // idle cycles with no strobe
      repeat (5) @(negedge clk);
      check("R9 idle hold");

      // R2 and R3: long run of strobes, hundredths through several seconds
      for (int i = 0; i < 300; i++) begin
         strobe();
         check((m_par == 1) ? "R2 first field no change" : "R2 R3 frame step");
      end

      // R4: seconds and minutes carry
      load(5, 3, 21, 10, 58, 59, 92, 1'b0);
      check("R8 load");
      for (int i = 0; i < 4; i++) begin
         strobe();
         check("R4 sec and min carry");
      end

      // R5: hour carry into day
      load(14, 7, 30, 23, 59, 59, 96, 1'b0);
      strobe(); check("R9 odd field hold");
      strobe(); check("R5 hour wrap into day");

      // R6 and R7: every month, leap and common years
      for (int yy = 0; yy < 2; yy++) begin
         for (int mo = 1; mo <= 12; mo++) begin
            int yr;
            yr = (yy == 0) ? 23 : 24;
            load(month_days(mo, yr), mo, yr, 23, 59, 59, 96, 1'b0);
            strobe(); check("R6 last day hold");
            strobe(); check((mo == 12) ? "R7 month wrap" : "R6 month length rollover");
         end
      end
      // February in year 00 counts as leap
      load(28, 2, 0, 23, 59, 59, 96, 1'b0);
      strobe(); strobe(); check("R6 feb 28 to 29 in year 00");

      // R7: full chain to year wrap
      load(31, 12, 99, 23, 59, 59, 96, 1'b0);
      strobe(); strobe(); check("R7 year 99 wrap");

      // R8: load coincident with completing strobe, pairing restarts
      load(2, 2, 2, 2, 2, 2, 0, 1'b0);
      strobe(); check("R2 first field");
      load(9, 9, 9, 9, 9, 9, 8, 1'b1);
      check("R8 load beats frame");
      strobe(); check("R8 pairing restart no change");
      strobe(); check("R8 advance after two strobes");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule